// File: doc/BRIEF.md
# In-Order Completion Buffer

This block reorders results. A requester takes a token when it issues a request, and the token is the index of a slot in a circular array. The producer that serves the request may finish at any later time and in any order, and it writes the result back into the slot that the token names. The consumer sees results strictly in the order the tokens were handed out. The head result is offered only when its own slot holds data. Younger results that are already present wait behind it.

Within one cycle the four actions take effect in a fixed order: token allocation, then fill, then result read, then dequeue. A result written in a cycle is visible on the result port in that same cycle. When the buffer is empty, one cycle can allocate a token, fill it, present it and retire it. Allocation stalls when every slot is outstanding.

Top module: `cbuf_top`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o` is 1, `res_valid_o` is 0 and `alloc_tok_o` is 0.
- R2: `alloc_ready_o` is 0 exactly when DEPTH tokens are outstanding (allocated but not yet dequeued), and 1 otherwise.
- R3: `alloc_tok_o` shows the token the next accepted allocation receives. Tokens are issued as 0, 1, ..., DEPTH-1, 0, ... and advance by one per accepted allocation.
- R4: Fills may arrive in any order. `res_valid_o` is 1 only when a token is outstanding and the oldest outstanding token has been filled. Results leave in token order.
- R5: When `res_valid_o` is 1, `res_data_o` equals the data most recently filled into the oldest outstanding token. A fill to that token in the current cycle is presented in the same cycle.
- R6: On an empty buffer, allocating a token, filling it and dequeuing it in the same cycle is accepted, and the buffer is empty again afterwards.
- R7: `deq_i` while `res_valid_o` is 0 has no effect: the head token stays outstanding and its later result is still delivered.
- R8: An allocation and a dequeue in the same cycle leave the number of outstanding tokens unchanged.
- R9: `alloc_req_i` while `alloc_ready_o` is 0 has no effect: the token does not advance and no slot is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Request a token this cycle |
| alloc_ready_o | output | 1 | A token can be allocated |
| alloc_tok_o | output | $clog2(DEPTH) | Token given to an accepted allocation |
| fill_valid_i | input | 1 | Write a result this cycle |
| fill_tok_i | input | $clog2(DEPTH) | Token whose slot receives the result |
| fill_data_i | input | DATA_W | Result data |
| res_valid_o | output | 1 | Head result is available |
| res_data_o | output | DATA_W | Head result data |
| deq_i | input | 1 | Retire the head result |

## Verification
The hardest situation to reach is a cycle where allocation, fill and dequeue all act on the same slot. This happens when the buffer is empty and the just-issued token is filled and retired at once, and it tests every bypass path together. The bench drives this directly from the empty state by filling the token shown on `alloc_tok_o` in the same cycle. It also fills a full buffer in reverse token order, so the head stays blocked until the very last fill. Long mixed runs with random fill order and dequeue attempts on an unfilled head wrap the pointers many times.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/cbuf_ptr.sv
module cbuf_ptr #(
  parameter int DEPTH = 8,
  localparam int IdxW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [IdxW-1:0] idx_o
);
  logic [IdxW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= IdxW'(cbuf_pkg::wrap_inc(int'(idx_q), DEPTH));
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/cbuf_occ.sv
module cbuf_occ #(
  parameter int DEPTH = 8,
  localparam int CntW = $clog2(DEPTH) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            dec_i,
  output logic [CntW-1:0] cnt_o,
  output logic            full_o
);
  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CntW'(DEPTH));
endmodule

// File: rtl/cbuf_slots.sv
module cbuf_slots #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IdxW  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_a_i,
  input  logic [IdxW-1:0]   clr_a_idx_i,
  input  logic              fill_i,
  input  logic [IdxW-1:0]   fill_idx_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              clr_d_i,
  input  logic [IdxW-1:0]   clr_d_idx_i,
  input  logic [IdxW-1:0]   rd_idx_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] dat_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_a, hit_f, hit_d;
    assign hit_a = clr_a_i && (clr_a_idx_i == IdxW'(i));
    assign hit_f = fill_i  && (fill_idx_i  == IdxW'(i));
    assign hit_d = clr_d_i && (clr_d_idx_i == IdxW'(i));

    // priority mirrors port order: dequeue over fill over allocate
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_q[i] <= 1'b0;
      else if (hit_d) vld_q[i] <= 1'b0;
      else if (hit_f) vld_q[i] <= 1'b1;
      else if (hit_a) vld_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    dat_q[i] <= '0;
      else if (hit_f) dat_q[i] <= fill_data_i;
    end
  end

  logic byp_fill, byp_clr;
  assign byp_fill = fill_i  && (fill_idx_i  == rd_idx_i);
  assign byp_clr  = clr_a_i && (clr_a_idx_i == rd_idx_i);

  always_comb begin
    if (byp_fill)     rd_valid_o = 1'b1;
    else if (byp_clr) rd_valid_o = 1'b0;
    else              rd_valid_o = vld_q[rd_idx_i];
    rd_data_o = byp_fill ? fill_data_i : dat_q[rd_idx_i];
  end
endmodule

// File: rtl/cbuf_top.sv
module cbuf_top #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IdxW  = $clog2(DEPTH),
  localparam int CntW  = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_req_i,
  output logic              alloc_ready_o,
  output logic [IdxW-1:0]   alloc_tok_o,
  input  logic              fill_valid_i,
  input  logic [IdxW-1:0]   fill_tok_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  input  logic              deq_i
);
  logic [IdxW-1:0] ins_idx, rem_idx;
  logic [CntW-1:0] cnt_q;
  logic            full, alloc_fire, deq_fire, head_live, slot_vld;

  assign alloc_ready_o = !full;
  assign alloc_fire    = alloc_req_i && !full;
  assign alloc_tok_o   = ins_idx;
  // count as seen after this cycle's allocation
  assign head_live     = (cnt_q != '0) || alloc_fire;
  assign res_valid_o   = head_live && slot_vld;
  assign deq_fire      = deq_i && res_valid_o;

  cbuf_ptr #(.DEPTH(DEPTH)) u_ins (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(alloc_fire), .idx_o(ins_idx)
  );

  cbuf_ptr #(.DEPTH(DEPTH)) u_rem (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(deq_fire), .idx_o(rem_idx)
  );

  cbuf_occ #(.DEPTH(DEPTH)) u_occ (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(alloc_fire), .dec_i(deq_fire),
    .cnt_o(cnt_q), .full_o(full)
  );

  cbuf_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_a_i(alloc_fire), .clr_a_idx_i(ins_idx),
    .fill_i(fill_valid_i), .fill_idx_i(fill_tok_i), .fill_data_i(fill_data_i),
    .clr_d_i(deq_fire), .clr_d_idx_i(rem_idx),
    .rd_idx_i(rem_idx), .rd_valid_o(slot_vld), .rd_data_o(res_data_o)
  );
endmodule

// File: rtl/cbuf_top_chk.sv
module cbuf_top_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IdxW  = $clog2(DEPTH),
  localparam int CntW  = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              alloc_req_i,
  input logic              alloc_ready_o,
  input logic [IdxW-1:0]   alloc_tok_o,
  input logic              fill_valid_i,
  input logic [IdxW-1:0]   fill_tok_i,
  input logic [DATA_W-1:0] fill_data_i,
  input logic              res_valid_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic              deq_i,
  input logic [CntW-1:0]   cnt_q,
  input logic [IdxW-1:0]   rem_idx
);
  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CntW'(DEPTH));

  // R2
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CntW'(DEPTH)) |-> !alloc_ready_o);

  // R3
  tok_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_req_i && alloc_ready_o) |=>
      alloc_tok_o == (($past(alloc_tok_o) == IdxW'(DEPTH-1)) ? '0 : $past(alloc_tok_o) + 1'b1));

  // R9
  tok_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_req_i && alloc_ready_o) |=> $stable(alloc_tok_o));

  // R4
  empty_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !(alloc_req_i && alloc_ready_o)) |-> !res_valid_o);

  // R5
  fill_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_tok_i == rem_idx && (cnt_q != '0 || (alloc_req_i && alloc_ready_o)))
      |-> (res_valid_o && res_data_o == fill_data_i));

  // R8
  cnt_balance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_req_i && alloc_ready_o && deq_i && res_valid_o) |=> $stable(cnt_q));

  // R7
  deq_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_i && !res_valid_o) |=> $stable(rem_idx));
endmodule

bind cbuf_top cbuf_top_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .alloc_req_i(alloc_req_i),
  .alloc_ready_o(alloc_ready_o), .alloc_tok_o(alloc_tok_o),
  .fill_valid_i(fill_valid_i), .fill_tok_i(fill_tok_i), .fill_data_i(fill_data_i),
  .res_valid_o(res_valid_o), .res_data_o(res_data_o), .deq_i(deq_i),
  .cnt_q(cnt_q), .rem_idx(rem_idx)
);

// File: tb/cbuf_top_test.sv
module cbuf_top_test;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int IW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_req = 1'b0;
  logic              alloc_ready;
  logic [IW-1:0]     alloc_tok;
  logic              fill_valid = 1'b0;
  logic [IW-1:0]     fill_tok = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              res_valid;
  logic [DATA_W-1:0] res_data;
  logic              deq = 1'b0;

  int errors = 0;
  int checks = 0;

  // reference model: outstanding tokens in issue order, filled results by token
  int                q[$];
  logic [DATA_W-1:0] fm[int];
  int                nxt = 0;

  always #5 clk = ~clk;

  cbuf_top #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_req_i(alloc_req), .alloc_ready_o(alloc_ready), .alloc_tok_o(alloc_tok),
    .fill_valid_i(fill_valid), .fill_tok_i(fill_tok), .fill_data_i(fill_data),
    .res_valid_o(res_valid), .res_data_o(res_data), .deq_i(deq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // fmode: 0 none, 1 random unfilled, 2 token allocated now, 3 oldest unfilled, 4 youngest unfilled
  task automatic step(input bit a, input int fmode, input bit d, input string tag);
    bit   exp_ready, afire, fv, exp_valid;
    int   qe[$];
    int   cands[$];
    int   ftok;
    logic [DATA_W-1:0] fdat, exp_data;
    @(negedge clk);
    exp_ready = (q.size() < DEPTH);
    afire = a && exp_ready;
    qe = q;
    if (afire) qe.push_back(nxt);
    foreach (qe[i]) if (!fm.exists(qe[i])) cands.push_back(qe[i]);
    fv = 1'b0; ftok = 0;
    if (cands.size() > 0) begin
      case (fmode)
        1: begin fv = 1'b1; ftok = cands[$urandom_range(cands.size()-1)]; end
        2: if (afire) begin fv = 1'b1; ftok = nxt; end
        3: begin fv = 1'b1; ftok = cands[0]; end
        4: begin fv = 1'b1; ftok = cands[cands.size()-1]; end
        default: fv = 1'b0;
      endcase
    end
    fdat = $urandom;
    alloc_req  = a;
    fill_valid = fv;
    fill_tok   = IW'(ftok);
    fill_data  = fdat;
    deq        = d;
    #2;
    exp_valid = 1'b0; exp_data = '0;
    if (qe.size() > 0) begin
      if (fv && ftok == qe[0]) begin exp_valid = 1'b1; exp_data = fdat; end
      else if (fm.exists(qe[0])) begin exp_valid = 1'b1; exp_data = fm[qe[0]]; end
    end
    chk({tag, "/R2 ready"}, 64'(alloc_ready), 64'(exp_ready));
    chk({tag, "/R3 token"}, 64'(alloc_tok), 64'(nxt));
    chk({tag, "/R4 valid"}, 64'(res_valid), 64'(exp_valid));
    if (exp_valid) chk({tag, "/R5 data"}, 64'(res_data), 64'(exp_data));
    @(posedge clk);
    if (afire) begin q.push_back(nxt); nxt = (nxt + 1) % DEPTH; end
    if (fv) fm[ftok] = fdat;
    if (d && exp_valid) begin fm.delete(q[0]); void'(q.pop_front()); end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #22;
    // R1: reset state
    chk("R1 ready", 64'(alloc_ready), 64'd1);
    chk("R1 valid", 64'(res_valid), 64'd0);
    chk("R1 token", 64'(alloc_tok), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, "R1");

    // R6: allocate, fill and retire on empty in one cycle
    for (int i = 0; i < 3; i++) step(1, 2, 1, "R6");
    step(0, 0, 0, "R6 after");

    // R2/R9: fill up without fills, then push on full
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, "R2 fillup");
    step(1, 0, 0, "R9 alloc full");
    step(1, 0, 0, "R9 alloc full");
    // R7: dequeue on unfilled head
    step(0, 0, 1, "R7 deq empty head");
    // R4: reverse-order fills, head blocked until last
    for (int i = 0; i < DEPTH; i++) step(0, 4, 1, "R4 reverse");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, "R4 drain");
    step(0, 0, 1, "R7 deq on empty");

    // R8: allocate and dequeue together while full
    for (int i = 0; i < DEPTH; i++) step(1, 3, 0, "R8 fillup");
    for (int i = 0; i < 2 * DEPTH; i++) step(1, 3, 1, "R8 balance");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, "R8 drain");

    // R5: fill the head in the cycle it is dequeued
    for (int i = 0; i < 4; i++) step(1, 0, 0, "R5 setup");
    for (int i = 0; i < 4; i++) step(0, 3, 1, "R5 bypass");

    // mixed traffic, random fill order
    for (int i = 0; i < 4000; i++)
      step(($urandom_range(99) < 60), (($urandom_range(99) < 70) ? 1 : 0),
           ($urandom_range(99) < 55), "R4 mixed");
    while (q.size() > 0) step(0, 1, 1, "R4 flush");

    @(negedge clk);
    alloc_req = 1'b0; fill_valid = 1'b0; deq = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule